// File: doc/BRIEF.md
# Vectorised compare-immediate sequencer

This block carries out one signed compare-against-immediate operation across a run of elements. After a start pulse it walks an element index from zero up to the requested length minus one, handling one element per clock. For each element it reads one integer register through a combinational read port and compares the value with a sign-extended immediate. It then writes a four-bit condition field through a write port in the same cycle.

Two mode bits pick the access pattern. The source bit makes the register read step through consecutive registers. The destination bit makes the condition-field write step through consecutive fields. Each bit acts independently, so one sequencer covers the scalar-to-scalar, scalar-to-vector, vector-to-scalar and vector-to-vector forms. Every element in the run is processed. There is no masking and no early exit.

Top module: `vcmpi_seq`

## Requirements
- R1: After reset, `busy`, `done` and `cr_we` are low.
- R2: A start pulse with length N > 0, taken while idle, raises `busy` from the next cycle for exactly N cycles. `cr_we` is high in each of those cycles, so exactly N field writes occur.
- R3: The compare is signed, with the immediate sign-extended to the register width. The written field is {LT, GT, EQ, SO} at bits 3, 2, 1 and 0, and exactly one of LT, GT and EQ is set.
- R4: Bit 0 (SO) of each written field equals `so_in` in the cycle of that write.
- R5: For element i the read address is `ra + i` when the source mode bit is set, and `ra` otherwise, taken modulo NREGS.
- R6: For element i the write address is `ba + i` when the destination mode bit is set, and `ba` otherwise, taken modulo NCRF. This holds independently of the source mode.
- R7: `done` is high for exactly one cycle, the cycle after the last write, and `busy` is low in that cycle.
- R8: A start with length 0 performs no write, never raises `busy`, and pulses `done` in the cycle after start.
- R9: A start pulse while `busy` is high is ignored. The run in progress keeps its length and addresses.
- R10: The operands are captured at start. Changes on `vl`, `ba`, `ra`, `si` and the mode bits during a run do not affect its writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| vl | input | VLW | Number of elements |
| ba | input | CRW | Base condition-field index |
| ra | input | RIW | Base source register index |
| si | input | SIW | Signed immediate |
| src_vec | input | 1 | Source steps per element when high |
| dst_vec | input | 1 | Destination steps per element when high |
| so_in | input | 1 | Summary-overflow value copied into each field |
| rd_addr | output | RIW | Register read address |
| rd_data | input | XLEN | Register read data, same cycle |
| cr_we | output | 1 | Condition-field write enable |
| cr_addr | output | CRW | Condition-field write index |
| cr_data | output | 4 | Field value {LT, GT, EQ, SO} |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `rd_data` is a settled combinational function of `rd_addr` within each cycle. They also assume that `so_in` is a defined level, so the compare flags and the SO copy always see known values. The bench models the register file as a plain array read combinationally from `rd_addr`. It changes `so_in`, the operands and `start` only at falling edges, so each write sees stable data. It holds `so_in` constant across each run. The disturbance test changes operands only while a run is busy.

// File: rtl/vcmpi_seq.sv
module vcmpi_seq #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int NCRF  = 8,
  parameter int SIW   = 16,
  parameter int VLW   = 7,
  localparam int RIW  = $clog2(NREGS),
  localparam int CRW  = $clog2(NCRF)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VLW-1:0]  vl,
  input  logic [CRW-1:0]  ba,
  input  logic [RIW-1:0]  ra,
  input  logic [SIW-1:0]  si,
  input  logic            src_vec,
  input  logic            dst_vec,
  input  logic            so_in,
  output logic [RIW-1:0]  rd_addr,
  input  logic [XLEN-1:0] rd_data,
  output logic            cr_we,
  output logic [CRW-1:0]  cr_addr,
  output logic [3:0]      cr_data,
  output logic            busy,
  output logic            done
);

  logic [VLW-1:0] idx, vl_q;
  logic [CRW-1:0] ba_q;
  logic [RIW-1:0] ra_q;
  logic [SIW-1:0] si_q;
  logic           sv_q, dv_q, busy_q, done_q;

  logic [XLEN-1:0] imm;
  logic            lt, gt, eq, last;

  assign imm     = {{(XLEN-SIW){si_q[SIW-1]}}, si_q};
  assign lt      = $signed(rd_data) < $signed(imm);
  assign eq      = rd_data == imm;
  assign gt      = !lt && !eq;
  assign last    = idx == vl_q - VLW'(1);

  assign rd_addr = ra_q + (sv_q ? RIW'(idx) : RIW'(0));
  assign cr_addr = ba_q + (dv_q ? CRW'(idx) : CRW'(0));
  assign cr_data = {lt, gt, eq, so_in};
  assign cr_we   = busy_q;
  assign busy    = busy_q;
  assign done    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx    <= '0;
      vl_q   <= '0;
      ba_q   <= '0;
      ra_q   <= '0;
      si_q   <= '0;
      sv_q   <= 1'b0;
      dv_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          idx  <= '0;
          vl_q <= vl;
          ba_q <= ba;
          ra_q <= ra;
          si_q <= si;
          sv_q <= src_vec;
          dv_q <= dst_vec;
          if (vl == '0) done_q <= 1'b1;
          else          busy_q <= 1'b1;
        end
      end else begin
        idx <= idx + VLW'(1);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vcmpi_seq_chk.sv
module vcmpi_seq_chk #(
  parameter int RIW = 5,
  parameter int CRW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [RIW-1:0] rd_addr,
  input logic           cr_we,
  input logic [CRW-1:0] cr_addr,
  input logic [3:0]     cr_data,
  input logic           so_in,
  input logic           busy,
  input logic           done
);

  a_r3_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> $countones(cr_data[3:1]) == 1);

  a_r4_so_copy: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> cr_data[0] == so_in);

  a_r5_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we && $past(cr_we)) |->
      (rd_addr == $past(rd_addr) || rd_addr == RIW'($past(rd_addr) + 1'b1)));

  a_r6_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we && $past(cr_we)) |->
      (cr_addr == $past(cr_addr) || cr_addr == CRW'($past(cr_addr) + 1'b1)));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

bind vcmpi_seq vcmpi_seq_chk #(.RIW(RIW), .CRW(CRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .cr_we(cr_we),
  .cr_addr(cr_addr), .cr_data(cr_data), .so_in(so_in),
  .busy(busy), .done(done)
);

// File: tb/vcmpi_seq_tb.sv
module vcmpi_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32, NREGS = 32, NCRF = 8, SIW = 16, VLW = 7;
  localparam int RIW = $clog2(NREGS), CRW = $clog2(NCRF);

  logic clk = 0, rst_n = 0, start = 0, src_vec = 0, dst_vec = 0, so_in = 0;
  logic [VLW-1:0]  vl = '0;
  logic [CRW-1:0]  ba = '0;
  logic [RIW-1:0]  ra = '0;
  logic [SIW-1:0]  si = '0;
  logic [RIW-1:0]  rd_addr;
  logic [XLEN-1:0] rd_data;
  logic            cr_we, busy, done;
  logic [CRW-1:0]  cr_addr;
  logic [3:0]      cr_data;

  logic [XLEN-1:0] regs [NREGS];
  logic [CRW-1:0]  wa [256];
  logic [3:0]      wd [256];
  int wr_cnt = 0;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rd_data = regs[rd_addr];

  vcmpi_seq #(.XLEN(XLEN), .NREGS(NREGS), .NCRF(NCRF), .SIW(SIW), .VLW(VLW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .ba(ba), .ra(ra), .si(si),
    .src_vec(src_vec), .dst_vec(dst_vec), .so_in(so_in), .rd_addr(rd_addr),
    .rd_data(rd_data), .cr_we(cr_we), .cr_addr(cr_addr), .cr_data(cr_data),
    .busy(busy), .done(done));

  always @(posedge clk) begin
    if (cr_we && wr_cnt < 256) begin
      wa[wr_cnt] <= cr_addr;
      wd[wr_cnt] <= cr_data;
      wr_cnt     <= wr_cnt + 1;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_field(logic [XLEN-1:0] v, logic [SIW-1:0] imm, logic so);
    logic signed [XLEN-1:0] sv, si_ext;
    sv = v;
    si_ext = {{(XLEN-SIW){imm[SIW-1]}}, imm};
    return {sv < si_ext, sv > si_ext, sv == si_ext, so};
  endfunction

  task automatic do_run(int n, int b, int r, logic [SIW-1:0] imm, bit svec, bit dvec, bit so, bit disturb);
    int base, k, busy_bad;
    busy_bad = 0;
    @(negedge clk);
    base = wr_cnt;
    vl = VLW'(n); ba = CRW'(b); ra = RIW'(r); si = imm;
    src_vec = svec; dst_vec = dvec; so_in = so; start = 1;
    @(negedge clk);
    start = 0;
    k = 0;
    while (!done && k < 200) begin
      if (!busy) busy_bad++;
      if (disturb && k == 1) begin
        start = 1; vl = VLW'(n + 3); ba = CRW'(b + 2); ra = RIW'(r + 5);
        si = ~imm; src_vec = ~svec; dst_vec = ~dvec;
      end else if (disturb && k == 2) begin
        start = 0;
      end
      @(negedge clk);
      k++;
    end
    check(k == n, "R2/R7 done latency", k, n);
    check(busy_bad == 0, "R2 busy held", busy_bad, 0);
    check(!busy, "R7 busy low with done", busy, 0);
    @(negedge clk);
    check(!done, "R7 single done pulse", done, 0);
    check(wr_cnt - base == n, disturb ? "R9 write count" : "R2/R8 write count", wr_cnt - base, n);
    for (int i = 0; i < n && base + i < 256; i++) begin
      int ea, ed;
      ea = (b + (dvec ? i : 0)) % NCRF;
      ed = exp_field(regs[(r + (svec ? i : 0)) % NREGS], imm, so);
      check(wa[base+i] == CRW'(ea), disturb ? "R10 dst index" : "R6 dst index", wa[base+i], ea);
      check(wd[base+i] == 4'(ed), disturb ? "R10 field" : "R3/R4/R5 field", wd[base+i], ed);
    end
  endtask

  task automatic t_reset();
    check(!busy, "R1 busy", busy, 0);
    check(!done, "R1 done", done, 0);
    check(!cr_we, "R1 cr_we", cr_we, 0);
  endtask

  task automatic t_vec_vec();       do_run(5, 2, 13, 16'd0, 1, 1, 0, 0); endtask
  task automatic t_scalar_scalar(); do_run(3, 5, 2, 16'hffff, 0, 0, 1, 0); endtask
  task automatic t_dst_wrap();      do_run(4, 6, 1, 16'h7fff, 0, 1, 0, 0); endtask
  task automatic t_src_wrap();      do_run(4, 3, 30, 16'h8000, 1, 0, 1, 0); endtask
  task automatic t_zero_len();      do_run(0, 1, 4, 16'd5, 1, 1, 1, 0); endtask
  task automatic t_long();          do_run(40, 0, 0, 16'hfc18, 1, 1, 0, 0); endtask
  task automatic t_start_busy();    do_run(6, 4, 10, 16'hf830, 1, 0, 1, 1); endtask

  initial begin
    regs[0] = 32'h8000_0000;
    regs[1] = 32'h7fff_ffff;
    regs[2] = 32'hffff_ffff;
    for (int i = 3; i < NREGS; i++) regs[i] = XLEN'(i * 1000 - 15000);
    #(CLK_PERIOD * 3);
    t_reset();
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_vec_vec();
    t_scalar_scalar();
    t_dst_wrap();
    t_src_wrap();
    t_zero_len();
    t_long();
    t_start_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule